// File: doc/BRIEF.md
# Two-Phase Vector FP Exception Sequencer

This controller steps one vector floating-point instruction through exception handling. The handling runs in two phases. In the first phase it examines the conditions found before computation: invalid operand, divide-by-zero and denormal operand. In the second phase it examines the conditions found after computation: overflow, underflow and inexact. The status unit supplies the raw condition bits and their mask bits.

In each phase the sequencer pulses a flag strobe that carries that phase's flag bits. Masked and unmasked conditions both appear in these bits. If any condition in the phase is unmasked, the sequencer also raises a one-cycle trap request. It then holds the instruction, with source and destination untouched, until the handler signals its return. The trap kind is chosen by an OS-support enable. When the enable is set the trap is a floating-point exception. When it is clear the trap is an invalid-opcode trap. Because there are two phases, one instruction can trap twice.

The destination is written only through the final commit pulse. This pulse comes after all post-computation handling is finished, so masked results never land early.

Top module: `fpx_trap_seq`

## Requirements
- R1: A `start` pulse while `busy` is low begins an instruction, and `busy` is high from the next cycle through the cycle of `commit`, then low. A `start` while `busy` is high has no effect.
- R2: In the cycle after `start`, `flag_set` pulses with the pre-computation flags on `flag_bits`: bit 0 invalid, bit 1 divide-by-zero, bit 2 denormal, and bits 5:3 zero. A flag is reported whether it is masked or not.
- R3: If any pre-computation condition is unmasked (raised with its mask bit 0), `trap_req` pulses for one cycle together with that flag strobe. The sequencer then waits, with no `commit` and no further trap, until `handler_done`.
- R4: `trap_kind` is 0 (FP exception) when `os_trap_en` is 1, and 1 (invalid opcode) when `os_trap_en` is 0.
- R5: The post-computation check follows in the cycle after the pre check when no trap was raised, or in the cycle after `handler_done`. It pulses `flag_set` with bit 3 overflow, bit 4 underflow, bit 5 inexact, and bits 2:0 zero.
- R6: A masked underflow that comes without inexact leaves bit 4 clear. A masked underflow with inexact, or any unmasked underflow, sets bit 4.
- R7: Any unmasked post-computation condition raises a second one-cycle `trap_req`, and the sequencer then waits for `handler_done` before committing.
- R8: `commit` is a one-cycle pulse, issued exactly once per instruction. It comes in the cycle after the post check when no post trap was raised, or in the cycle after the post handler returns.
- R9: `handler_done` outside a wait state has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin sequencing one instruction |
| pre_cond | input | 3 | Pre-computation conditions {denormal, divzero, invalid} |
| pre_mask | input | 3 | Mask bits for pre_cond, 1 = masked |
| post_cond | input | 3 | Post-computation conditions {inexact, underflow, overflow} |
| post_mask | input | 3 | Mask bits for post_cond, 1 = masked |
| os_trap_en | input | 1 | OS support for FP-exception traps |
| handler_done | input | 1 | Handler return handshake |
| busy | output | 1 | Instruction in flight |
| trap_req | output | 1 | One-cycle trap request |
| trap_kind | output | 1 | 0 = FP exception, 1 = invalid opcode |
| flag_set | output | 1 | Strobe: OR flag_bits into sticky flags |
| flag_bits | output | 6 | Flag bits of the current phase |
| commit | output | 1 | One-cycle destination write / completion |

## Verification
Some properties are checked on every cycle by the embedded assertions. Trap requests and commits last one cycle. Every trap has a flag strobe beside it and the kind that matches the OS enable. A commit is always followed by idle, and no commit falls inside a handler wait. The bench scenarios show the ordering between phases: a double trap on one instruction, post flags held back until the pre handler returns, and the underflow-without-inexact rule. Only the scenarios can also show that stray `start` and `handler_done` pulses leave the sequence unchanged.

// File: rtl/fpx_trap_seq.sv
module fpx_trap_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] pre_cond,
  input  logic [2:0] pre_mask,
  input  logic [2:0] post_cond,
  input  logic [2:0] post_mask,
  input  logic       os_trap_en,
  input  logic       handler_done,
  output logic       busy,
  output logic       trap_req,
  output logic       trap_kind,
  output logic       flag_set,
  output logic [5:0] flag_bits,
  output logic       commit
);
  typedef enum logic [2:0] {
    S_IDLE, S_PRE_CHK, S_PRE_WAIT, S_POST_CHK, S_POST_WAIT, S_COMMIT
  } state_t;

  state_t state, nxt;

  logic       pre_hit, post_hit;
  logic [2:0] post_rep;

  assign pre_hit  = |(pre_cond & ~pre_mask);
  assign post_hit = |(post_cond & ~post_mask);
  // masked underflow is only reported when accompanied by inexact
  assign post_rep = {post_cond[2],
                     post_cond[1] & (post_cond[2] | ~post_mask[1]),
                     post_cond[0]};

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:      if (start) nxt = S_PRE_CHK;
      S_PRE_CHK:   nxt = pre_hit ? S_PRE_WAIT : S_POST_CHK;
      S_PRE_WAIT:  if (handler_done) nxt = S_POST_CHK;
      S_POST_CHK:  nxt = post_hit ? S_POST_WAIT : S_COMMIT;
      S_POST_WAIT: if (handler_done) nxt = S_COMMIT;
      S_COMMIT:    nxt = S_IDLE;
      default:     nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end

  assign busy      = (state != S_IDLE);
  assign flag_set  = (state == S_PRE_CHK) || (state == S_POST_CHK);
  assign flag_bits = (state == S_PRE_CHK)  ? {3'b000, pre_cond} :
                     (state == S_POST_CHK) ? {post_rep, 3'b000} : 6'b0;
  assign trap_req  = ((state == S_PRE_CHK) && pre_hit) ||
                     ((state == S_POST_CHK) && post_hit);
  assign trap_kind = trap_req & ~os_trap_en;
  assign commit    = (state == S_COMMIT);

  AST_TRAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> !trap_req); // R3
  AST_TRAP_HAS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> flag_set); // R3
  AST_TRAP_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (trap_kind == !os_trap_en)); // R4
  AST_POST_TRAP_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && flag_bits[2:0] == 3'b000) |=> !commit); // R7
  AST_COMMIT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (!busy && !commit)); // R8
  AST_COMMIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (busy && !trap_req && !flag_set)); // R1
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && flag_set)); // R2
endmodule

// File: tb/fpx_trap_seq_tb.sv
module fpx_trap_seq_tb;
  logic clk = 0, rst_n = 0, start = 0, os_trap_en = 1, handler_done = 0;
  logic [2:0] pre_cond = 0, pre_mask = 3'b111, post_cond = 0, post_mask = 3'b111;
  logic busy, trap_req, trap_kind, flag_set, commit;
  logic [5:0] flag_bits;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fpx_trap_seq u_dut (.clk(clk), .rst_n(rst_n), .start(start), .pre_cond(pre_cond),
    .pre_mask(pre_mask), .post_cond(post_cond), .post_mask(post_mask),
    .os_trap_en(os_trap_en), .handler_done(handler_done), .busy(busy),
    .trap_req(trap_req), .trap_kind(trap_kind), .flag_set(flag_set),
    .flag_bits(flag_bits), .commit(commit));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic outs(input string req, input bit b, input bit t, input bit k,
                      input bit f, input int fb, input bit c);
    int act, exp;
    act = {busy, trap_req, trap_kind, flag_set, flag_bits, commit};
    exp = {b, t, k, f, fb[5:0], c};
    chk(act == exp, req, act, exp);
  endtask

  task automatic go(input logic [2:0] pc, pm, qc, qm, input bit os);
    pre_cond = pc; pre_mask = pm; post_cond = qc; post_mask = qm; os_trap_en = os;
    start = 1; step(); start = 0;
  endtask

  task automatic t_reset();
    outs("R1 reset", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_clean();
    go(0, 3'b111, 0, 3'b111, 1);
    outs("R2 clean pre", 1, 0, 0, 1, 0, 0); step();
    outs("R5 clean post", 1, 0, 0, 1, 0, 0); step();
    outs("R8 clean commit", 1, 0, 0, 0, 0, 1); step();
    outs("R1 idle after commit", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_masked();
    go(3'b100, 3'b111, 3'b101, 3'b111, 1);
    outs("R2 masked denormal reported", 1, 0, 0, 1, 6'b000100, 0); step();
    outs("R5 masked ovf+inx reported", 1, 0, 0, 1, 6'b101000, 0); step();
    outs("R8 masked commit", 1, 0, 0, 0, 0, 1); step();
  endtask

  task automatic t_double(input bit os);
    int commits = 0;
    go(3'b011, 3'b110, 3'b001, 3'b110, os);
    outs("R3 R4 pre trap", 1, 1, !os, 1, 6'b000011, 0); step();
    for (int i = 0; i < 3; i++) begin
      if (i == 1) start = 1;
      outs("R3 pre wait holds", 1, 0, 0, 0, 0, 0); step();
      start = 0;
    end
    handler_done = 1; step(); handler_done = 0;
    outs("R7 R4 post trap", 1, 1, !os, 1, 6'b001000, 0); step();
    for (int i = 0; i < 2; i++) begin
      outs("R7 post wait holds", 1, 0, 0, 0, 0, 0); step();
    end
    handler_done = 1; step(); handler_done = 0;
    outs("R8 commit after post handler", 1, 0, 0, 0, 0, 1);
    for (int i = 0; i < 4; i++) begin
      commits += commit; step();
    end
    chk(commits == 1, "R8 one commit", commits, 1);
    chk(!busy, "R1 busy low after commit", busy, 0);
  endtask

  task automatic t_underflow();
    go(0, 3'b111, 3'b010, 3'b111, 1); step();
    outs("R6 masked unf alone hidden", 1, 0, 0, 1, 0, 0); step(); step();
    go(0, 3'b111, 3'b110, 3'b111, 1); step();
    outs("R6 masked unf+inx shown", 1, 0, 0, 1, 6'b110000, 0); step(); step();
    go(0, 3'b111, 3'b010, 3'b101, 1); step();
    outs("R6 unmasked unf shown+trap", 1, 1, 0, 1, 6'b010000, 0); step();
    handler_done = 1; step(); handler_done = 0;
    outs("R8 commit after unf trap", 1, 0, 0, 0, 0, 1); step();
  endtask

  task automatic t_stray();
    handler_done = 1; step(); handler_done = 0;
    outs("R9 done in idle ignored", 0, 0, 0, 0, 0, 0);
    go(0, 3'b111, 0, 3'b111, 1);
    handler_done = 1;
    outs("R9 pre check unaffected", 1, 0, 0, 1, 0, 0); step();
    outs("R9 post check unaffected", 1, 0, 0, 1, 0, 0); step();
    handler_done = 0;
    outs("R9 commit unaffected", 1, 0, 0, 0, 0, 1); step();
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1; step();
    t_reset();
    t_clean();
    t_masked();
    t_double(1);
    t_double(0);
    t_underflow();
    t_stray();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule